// File: doc/BRIEF.md
# Distributor control and identification registers

This block is the small register group at the front of an interrupt distributor. It holds the global distributor enable and a type word computed from the live count of shared interrupt lines and online CPU interfaces. It also holds a fixed identification word and a sticky flag that grants write access to the interrupt group registers. The group registers themselves live elsewhere; this block only drives the flag that permits writing them.

Two ports reach the registers. The main port is a plain 32-bit register bus with word-aligned accesses, and it ignores anything it cannot service. The configuration port is privileged: it reports errors, and it may write the identification word. Such a write is only a check. When the value matches the word, the group-write flag is set. When it differs, the write is refused with an error. Each time the enable goes from 0 to 1, the block emits a one-cycle wake pulse toward every CPU interface.

Top module: `dctl_regs`

## Requirements
- R1: While reset is asserted and just after it, `dist_enable`, `wake_pulse`, `group_wr_en`, `cfg_err`, `bus_rdata` and `cfg_rdata` are all 0.
- R2: Address bits [3:2] pick the register: 0 is control, 1 is type, 2 is identification, and 3 reads as zero. Address bits above bit 3 are not decoded. Read data is registered and appears on the rdata port of the requesting port in the cycle after the request. It holds until the next read on that port.
- R3: Control bit 0 is the global enable. A write to control loads bit 0 of the write data, and a read returns the enable in bit 0 with all other bits zero.
- R4: `wake_pulse` is high for exactly one cycle when a control write takes the enable from 0 to 1. It rises in the same cycle as `dist_enable`. A write of 1 while the enable is already 1, and any write of 0, produce no pulse.
- R5: The type word holds (32 + `spi_lines`)/32 − 1 in bits [4:0] and `cpu_count` − 1 in bits [7:5], with zeros above. It follows the count inputs as they change.
- R6: The identification word holds PRODUCT_ID in bits [31:24], REVISION in bits [15:12] and IMPLEMENTER in bits [11:0], with all other bits zero. With the default parameters it reads 0x0000_243B | 0x4B00_0000 = 0x4B00_243B.
- R7: Main-port writes to the type word, the identification word and offset 3 change nothing. A main-port access with address bits [1:0] not zero writes nothing, and a read of that kind returns zero.
- R8: On the configuration port, an access with address bits [1:0] not zero gets `cfg_err` = 1 in the following cycle and has no effect. A write to the identification word with a value that differs from it also gets `cfg_err` = 1 and has no effect.
- R9: A configuration-port write of exactly the identification word sets `group_wr_en`. The flag is visible in the following cycle, the write gets no error, and the flag stays set until reset, whatever writes follow.
- R10: The configuration port reads the same map as the main port and writes the control enable in the same way. A configuration-port write to the type word is ignored without an error.
- R11: If both ports write the control register in the same cycle, the configuration port's value is the one loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| spi_lines | input | SPI_W | Number of shared interrupt lines, a multiple of 32 |
| cpu_count | input | CPU_W | Number of online CPU interfaces, 1 to 8 |
| bus_req | input | 1 | Main port access request |
| bus_we | input | 1 | Main port write (1) or read (0) |
| bus_addr | input | ADDR_W | Main port byte address |
| bus_wdata | input | 32 | Main port write data |
| bus_rdata | output | 32 | Main port read data, registered |
| cfg_req | input | 1 | Configuration port access request |
| cfg_we | input | 1 | Configuration port write (1) or read (0) |
| cfg_addr | input | ADDR_W | Configuration port byte address |
| cfg_wdata | input | 32 | Configuration port write data |
| cfg_rdata | output | 32 | Configuration port read data, registered |
| cfg_err | output | 1 | One-cycle error response for the previous configuration access |
| dist_enable | output | 1 | Global distributor enable |
| wake_pulse | output | 1 | One-cycle kick to all CPU interfaces on enable rising |
| group_wr_en | output | 1 | Sticky permission to write the group registers |

## Verification
Every result of this block takes exactly one register stage. Read data, `cfg_err`, `dist_enable`, `wake_pulse` and `group_wr_en` all change on the clock edge that accepts the request. The bench drives each request at a falling edge, lets one rising edge pass, and samples on the next falling edge. After each control write it also samples one cycle later, to show the wake pulse has dropped again. Changes to the count inputs are made only while no access is in flight. The type word is then read back through a normal access, so it too is checked one cycle after the read request.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

  localparam int DATA_W = 32;

  // register select taken from address bits [3:2]
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_TYPE  = 2'd1,
    SEL_IDENT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // identification word field positions (decoded by software)
  localparam int ID_IMPL_LSB = 0;
  localparam int ID_IMPL_W   = 12;
  localparam int ID_REV_LSB  = 12;
  localparam int ID_REV_W    = 4;
  localparam int ID_PROD_LSB = 24;
  localparam int ID_PROD_W   = 8;

  // type word field positions
  localparam int TY_LINES_W  = 5;
  localparam int TY_CPU_LSB  = 5;
  localparam int TY_CPU_W    = 3;

  function automatic reg_sel_e decode_sel(input logic [1:0] word_idx);
    return reg_sel_e'(word_idx);
  endfunction

  function automatic logic [DATA_W-1:0] build_ident(
    input logic [ID_PROD_W-1:0] prod,
    input logic [ID_REV_W-1:0]  rev,
    input logic [ID_IMPL_W-1:0] impl
  );
    logic [DATA_W-1:0] w;
    w = '0;
    w[ID_PROD_LSB +: ID_PROD_W] = prod;
    w[ID_REV_LSB  +: ID_REV_W]  = rev;
    w[ID_IMPL_LSB +: ID_IMPL_W] = impl;
    return w;
  endfunction

endpackage

// File: rtl/dctl_type_word.sv
module dctl_type_word
  import dctl_pkg::*;
#(
  parameter int SPI_W = 10,
  parameter int CPU_W = 4
) (
  input  logic [SPI_W-1:0]  spi_lines,
  input  logic [CPU_W-1:0]  cpu_count,
  output logic [DATA_W-1:0] type_word
);

  localparam int TOT_W = SPI_W + 1;

  logic [TOT_W-1:0] total_lines;
  logic [TOT_W-1:0] blocks_m1;
  logic [CPU_W-1:0] cpus_m1;

  always_comb begin
    total_lines = TOT_W'(spi_lines) + TOT_W'(32);
    blocks_m1   = (total_lines >> 5) - TOT_W'(1);
    cpus_m1     = cpu_count - CPU_W'(1);
    type_word   = '0;
    type_word[TY_LINES_W-1:0]          = blocks_m1[TY_LINES_W-1:0];
    type_word[TY_CPU_LSB +: TY_CPU_W]  = cpus_m1[TY_CPU_W-1:0];
  end

endmodule

// File: rtl/dctl_enable_reg.sv
module dctl_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_ctrl_wr,
  input  logic bus_en_bit,
  input  logic cfg_ctrl_wr,
  input  logic cfg_en_bit,
  output logic enable,
  output logic wake
);

  logic en_q, en_d, en_ld;
  logic wake_q, wake_d;

  // next state: configuration port takes priority
  always_comb begin
    en_ld = cfg_ctrl_wr | bus_ctrl_wr;
    en_d  = en_q;
    if (cfg_ctrl_wr)      en_d = cfg_en_bit;
    else if (bus_ctrl_wr) en_d = bus_en_bit;
    wake_d = en_ld & en_d & ~en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (en_ld) en_q <= en_d;
      wake_q <= wake_d;
    end
  end

  assign enable = en_q;
  assign wake   = wake_q;

  AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (en_q && !$past(en_q))); // R4
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q); // R4
  AST_EN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $past(bus_ctrl_wr || cfg_ctrl_wr)); // R3
  AST_CFG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ctrl_wr |=> (en_q == $past(cfg_en_bit))); // R11

endmodule

// File: rtl/dctl_ident_gate.sv
module dctl_ident_gate
  import dctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic              cfg_aligned,
  input  reg_sel_e          cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] ident_word,
  output logic              cfg_err,
  output logic              grp_wr_en
);

  logic id_write, id_match;
  logic err_d, err_q;
  logic grp_d, grp_q, grp_ld;

  always_comb begin
    id_write = cfg_req & cfg_we & cfg_aligned & (cfg_sel == SEL_IDENT);
    id_match = (cfg_wdata == ident_word);
    err_d    = cfg_req & (~cfg_aligned | (id_write & ~id_match));
    grp_ld   = id_write & id_match;
    grp_d    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      grp_q <= 1'b0;
    end else begin
      err_q <= err_d;
      if (grp_ld) grp_q <= grp_d;
    end
  end

  assign cfg_err   = err_q;
  assign grp_wr_en = grp_q;

  AST_GRP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    grp_q |=> grp_q); // R9
  AST_GRP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_q) |-> ($past(cfg_req && cfg_we) && !err_q)); // R9
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(cfg_req)); // R8

endmodule

// File: rtl/dctl_read_port.sv
module dctl_read_port
  import dctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              aligned,
  input  reg_sel_e          sel,
  input  logic              enable,
  input  logic [DATA_W-1:0] type_word,
  input  logic [DATA_W-1:0] ident_word,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_d, rd_q;
  logic              rd_ld;

  always_comb begin
    rd_ld = req & ~we;
    rd_d  = '0;
    if (aligned) begin
      unique case (sel)
        SEL_CTRL:  rd_d = DATA_W'(enable);
        SEL_TYPE:  rd_d = type_word;
        SEL_IDENT: rd_d = ident_word;
        default:   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_ld) rd_q <= rd_d;
  end

  assign rdata = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_q) |-> $past(req && !we)); // R2

endmodule

// File: rtl/dctl_regs.sv
module dctl_regs
  import dctl_pkg::*;
#(
  parameter int                 ADDR_W      = 12,
  parameter int                 SPI_W       = 10,
  parameter int                 CPU_W       = 4,
  parameter logic [ID_PROD_W-1:0] PRODUCT_ID  = 8'h4B,
  parameter logic [ID_REV_W-1:0]  REVISION    = 4'd2,
  parameter logic [ID_IMPL_W-1:0] IMPLEMENTER = 12'h43B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPI_W-1:0]  spi_lines,
  input  logic [CPU_W-1:0]  cpu_count,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_err,
  output logic              dist_enable,
  output logic              wake_pulse,
  output logic              group_wr_en
);

  localparam logic [DATA_W-1:0] IDENT_WORD =
    build_ident(PRODUCT_ID, REVISION, IMPLEMENTER);
  localparam int NPORT = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  // per-port decode
  logic              p_req     [NPORT];
  logic              p_we      [NPORT];
  logic [ADDR_W-1:0] p_addr    [NPORT];
  logic              p_aligned [NPORT];
  reg_sel_e          p_sel     [NPORT];
  logic              p_ctrl_wr [NPORT];
  logic [DATA_W-1:0] p_rdata   [NPORT];

  always_comb begin
    p_req[0]  = bus_req;  p_we[0] = bus_we;  p_addr[0] = bus_addr;
    p_req[1]  = cfg_req;  p_we[1] = cfg_we;  p_addr[1] = cfg_addr;
  end

  logic [DATA_W-1:0] type_word;
  logic              en_q;

  dctl_type_word #(.SPI_W(SPI_W), .CPU_W(CPU_W)) u_type (
    .spi_lines (spi_lines),
    .cpu_count (cpu_count),
    .type_word (type_word)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    always_comb begin
      p_aligned[g] = (p_addr[g][1:0] == 2'b00);
      p_sel[g]     = decode_sel(p_addr[g][3:2]);
      p_ctrl_wr[g] = p_req[g] & p_we[g] & p_aligned[g] & (p_sel[g] == SEL_CTRL);
    end

    dctl_read_port u_rd (
      .clk        (clk),
      .rst_n      (rst_s2),
      .req        (p_req[g]),
      .we         (p_we[g]),
      .aligned    (p_aligned[g]),
      .sel        (p_sel[g]),
      .enable     (en_q),
      .type_word  (type_word),
      .ident_word (IDENT_WORD),
      .rdata      (p_rdata[g])
    );
  end

  dctl_enable_reg u_en (
    .clk         (clk),
    .rst_n       (rst_s2),
    .bus_ctrl_wr (p_ctrl_wr[0]),
    .bus_en_bit  (bus_wdata[0]),
    .cfg_ctrl_wr (p_ctrl_wr[1]),
    .cfg_en_bit  (cfg_wdata[0]),
    .enable      (en_q),
    .wake        (wake_pulse)
  );

  dctl_ident_gate u_id (
    .clk         (clk),
    .rst_n       (rst_s2),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_aligned (p_aligned[1]),
    .cfg_sel     (p_sel[1]),
    .cfg_wdata   (cfg_wdata),
    .ident_word  (IDENT_WORD),
    .cfg_err     (cfg_err),
    .grp_wr_en   (group_wr_en)
  );

  assign bus_rdata   = p_rdata[0];
  assign cfg_rdata   = p_rdata[1];
  assign dist_enable = en_q;

  AST_BUS_ID_RO: assert property (@(posedge clk) disable iff (!rst_s2)
    (bus_req && bus_we && !cfg_req) |=> $stable(group_wr_en)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s2 |-> (!dist_enable && !wake_pulse && !group_wr_en && !cfg_err)); // R1

endmodule

// File: tb/test_dctl_regs.sv
module test_dctl_regs;

  localparam int ADDR_W = 12;
  localparam int SPI_W  = 10;
  localparam int CPU_W  = 4;
  localparam logic [31:0] ID_EXP = 32'h4B00_243B; // R6

  logic              clk = 1'b0;
  logic              rst_n;
  logic [SPI_W-1:0]  spi_lines;
  logic [CPU_W-1:0]  cpu_count;
  logic              bus_req, bus_we, cfg_req, cfg_we;
  logic [ADDR_W-1:0] bus_addr, cfg_addr;
  logic [31:0]       bus_wdata, cfg_wdata, bus_rdata, cfg_rdata;
  logic              cfg_err, dist_enable, wake_pulse, group_wr_en;

  int checks = 0;
  int errors = 0;
  bit model_en = 0;

  always #10 clk = ~clk;

  dctl_regs i_dctl_regs (
    .clk(clk), .rst_n(rst_n), .spi_lines(spi_lines), .cpu_count(cpu_count),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .dist_enable(dist_enable), .wake_pulse(wake_pulse),
    .group_wr_en(group_wr_en)
  );

  function automatic logic [31:0] exp_type(int spi, int cpu);
    return 32'((((32 + spi) / 32) - 1) & 31) | 32'(((cpu - 1) & 7) << 5);
  endfunction

  function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a, bit en);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[3:2])
      2'd0:    return {31'h0, en};
      2'd1:    return exp_type(int'(spi_lines), int'(cpu_count));
      2'd2:    return ID_EXP;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_acc(bit we, logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic cfg_acc(bit we, logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0;
  endtask

  // main-port write with enable and wake checks
  task automatic bus_write_checked(logic [ADDR_W-1:0] a, logic [31:0] d);
    bit old_en;
    bit exp_wake;
    old_en = model_en;
    if (a[1:0] == 2'b00 && a[3:2] == 2'd0) model_en = d[0];
    exp_wake = model_en & ~old_en;
    bus_acc(1'b1, a, d);
    chk("R4 wake after write", 32'(wake_pulse), 32'(exp_wake));
    chk("R3/R7 enable after write", 32'(dist_enable), 32'(model_en));
    @(negedge clk);
    chk("R4 wake one cycle", 32'(wake_pulse), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    cfg_req = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    spi_lines = 10'd0; cpu_count = 4'd1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 enable", 32'(dist_enable), 32'h0);
    chk("R1 wake", 32'(wake_pulse), 32'h0);
    chk("R1 group flag", 32'(group_wr_en), 32'h0);
    chk("R1 cfg_err", 32'(cfg_err), 32'h0);
    chk("R1 bus_rdata", bus_rdata, 32'h0);
    chk("R1 cfg_rdata", cfg_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 enable after release", 32'(dist_enable), 32'h0);

    // R5 type word corner values
    bus_acc(1'b0, 12'h004, 0);
    chk("R5 type minimum", bus_rdata, 32'h0);
    spi_lines = 10'd224; cpu_count = 4'd4;
    bus_acc(1'b0, 12'h004, 0);
    chk("R5 type 256 lines 4 cpus", bus_rdata, 32'h0000_0067);
    spi_lines = 10'd992; cpu_count = 4'd8;
    cfg_acc(1'b0, 12'h004, 0);
    chk("R5/R10 type maximum on cfg", cfg_rdata, 32'h0000_00FF);

    // R6 ident, R2 unused offset and aliasing
    bus_acc(1'b0, 12'h008, 0);
    chk("R6 ident word", bus_rdata, ID_EXP);
    bus_acc(1'b0, 12'h00C, 0);
    chk("R2 offset 3 reads zero", bus_rdata, 32'h0);
    bus_acc(1'b0, 12'hF48, 0);
    chk("R2 upper bits not decoded", bus_rdata, ID_EXP);

    // R3/R4 control
    bus_write_checked(12'h000, 32'hFFFF_FFFF);
    bus_acc(1'b0, 12'h000, 0);
    chk("R3 only bit0 reads", bus_rdata, 32'h1);
    bus_write_checked(12'h000, 32'h1); // already on: no pulse
    bus_write_checked(12'h000, 32'h0);

    // R7 ignored main-port writes
    bus_write_checked(12'h004, 32'hFFFF_FFFF);
    bus_write_checked(12'h008, ID_EXP);
    chk("R7 bus ident write no unlock", 32'(group_wr_en), 32'h0);
    bus_write_checked(12'h001, 32'h1);
    bus_acc(1'b0, 12'h004, 0);
    chk("R7 type unchanged", bus_rdata, 32'h0000_00FF);
    bus_acc(1'b0, 12'h00A, 0);
    chk("R7 misaligned read zero", bus_rdata, 32'h0);

    // R8 configuration errors
    cfg_acc(1'b1, 12'h008, ID_EXP ^ 32'h0000_1000);
    chk("R8 ident mismatch err", 32'(cfg_err), 32'h1);
    chk("R8 mismatch no unlock", 32'(group_wr_en), 32'h0);
    cfg_acc(1'b0, 12'h002, 0);
    chk("R8 misaligned read err", 32'(cfg_err), 32'h1);
    cfg_acc(1'b1, 12'h003, 32'h1);
    chk("R8 misaligned write err", 32'(cfg_err), 32'h1);
    chk("R8 misaligned write no effect", 32'(dist_enable), 32'h0);
    @(negedge clk);
    chk("R8 err is one cycle", 32'(cfg_err), 32'h0);

    // R10 cfg port control and type write
    cfg_acc(1'b1, 12'h004, 32'h0);
    chk("R10 cfg type write no err", 32'(cfg_err), 32'h0);
    cfg_acc(1'b1, 12'h000, 32'h1);
    model_en = 1'b1;
    chk("R10 cfg enable write", 32'(dist_enable), 32'h1);
    chk("R4 wake from cfg write", 32'(wake_pulse), 32'h1);
    cfg_acc(1'b0, 12'h000, 0);
    chk("R10 cfg ctrl read", cfg_rdata, 32'h1);

    // R11 simultaneous writes
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 12'h000; bus_wdata = 32'h1;
    cfg_req = 1; cfg_we = 1; cfg_addr = 12'h000; cfg_wdata = 32'h0;
    @(negedge clk);
    bus_req = 0; bus_we = 0; cfg_req = 0; cfg_we = 0;
    chk("R11 cfg wins (0)", 32'(dist_enable), 32'h0);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 12'h000; bus_wdata = 32'h0;
    cfg_req = 1; cfg_we = 1; cfg_addr = 12'h000; cfg_wdata = 32'h1;
    @(negedge clk);
    bus_req = 0; bus_we = 0; cfg_req = 0; cfg_we = 0;
    chk("R11 cfg wins (1)", 32'(dist_enable), 32'h1);
    chk("R11 wake on cfg rise", 32'(wake_pulse), 32'h1);
    model_en = 1'b1;

    // R9 unlock and stickiness
    cfg_acc(1'b1, 12'h008, ID_EXP);
    chk("R9 match no err", 32'(cfg_err), 32'h0);
    chk("R9 unlock", 32'(group_wr_en), 32'h1);
    cfg_acc(1'b1, 12'h008, 32'h0);
    chk("R9 sticky after mismatch", 32'(group_wr_en), 32'h1);
    chk("R8 later mismatch still err", 32'(cfg_err), 32'h1);

    // random main-port traffic
    for (int i = 0; i < 300; i++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] d;
      a = ADDR_W'($urandom);
      if (($urandom % 4) != 0) a[1:0] = 2'b00;
      d = $urandom;
      if (($urandom % 16) == 0) begin
        spi_lines = SPI_W'(32 * ($urandom % 32));
        cpu_count = CPU_W'(1 + ($urandom % 8));
        @(negedge clk);
      end
      if ($urandom % 2) begin
        bus_write_checked(a, d);
      end else begin
        bus_acc(1'b0, a, 0);
        chk("R2/R5 random read", bus_rdata, exp_read(a, model_en));
      end
    end
    chk("R9 flag held after traffic", 32'(group_wr_en), 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule